// File: doc/BRIEF.md
# Serial Port Status and Flag Controller

This block holds the bus-facing registers of a serial port that runs either clock-synchronous or asynchronous (UART) framing. One bus address serves both data directions: a write stores the byte for the transmitter, and a read returns the last received byte. A seven-flag status register records buffer state, transmit completion and receive errors. The flags are set by single-cycle pulses from the shift engines and cleared as side effects of bus accesses.

A control register selects the framing mode and the character length, and holds the transmit-enable and port-enable bits. Turning transmit on primes the transmitter flags and raises a transmit interrupt request, which software can later drop. Turning the port off wipes every flag. The shift registers, the bit-rate divider and the pin routing sit outside this block and connect through the pulse inputs.

Top module: `sio_flag_ctrl`

## Requirements
- R1: With `bus_sel`=0, a bus write loads `tx_data` from `bus_wdata`, and `bus_rdata` returns the stored receive byte.
- R2: When control bit 2 (7-bit characters) is 1, bit 7 of the receive byte returned on `bus_rdata` is 0.
- R3: With `bus_sel`=1, `bus_rdata` shows the status: bit0 transmit-empty, bit1 receive-full, bit2 transmit-shift-done, bit3 overrun, bit4 parity, bit5 framing, bit6 summing error (OR of the error causes), and bit7 always 0. All flags and the control register (`bus_sel`=2) read 0 after reset.
- R4: An `rx_xfer` pulse stores `rx_data`, sets receive-full and latches the parity and framing errors in that same clock edge. If receive-full was already 1 and the receive byte is not being read in that cycle, overrun is set and the byte is overwritten.
- R5: When control bit 1 is 1 (clock-synchronous mode), status bits 4 to 6 read 0.
- R6: A bus read with `bus_sel`=0 clears receive-full, unless `rx_xfer` arrives in the same cycle.
- R7: Any bus write with `bus_sel`=1 clears status bits 3 to 6 and leaves bits 0 to 2 unchanged. Errors raised by an `rx_xfer` in the same cycle still win.
- R8: A control write (`bus_sel`=2) with bit 7 (port enable) at 0 clears all seven status flags.
- R9: A control write that turns transmit on (bits 7 and 0 both 1 while they were not both 1 before) sets transmit-empty, transmit-shift-done and `tx_irq`. `tx_irq_clr` clears `tx_irq`, and the setting wins on a tie.
- R10: A data write clears transmit-empty and transmit-shift-done. `tx_load` sets transmit-empty and `tx_done` sets transmit-shift-done. The write wins on a tie.
- R11: While the port is disabled, engine pulses and data or status accesses leave the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_sel | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Bus read data for the selected register |
| tx_data | output | DW | Byte held for the transmit shifter |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_irq_clr | input | 1 | Software clear of the interrupt request |
| tx_load | input | 1 | Pulse: the shifter took the transmit byte |
| tx_done | input | 1 | Pulse: the shifter finished sending |
| rx_xfer | input | 1 | Pulse: a received byte is ready |
| rx_data | input | DW | Received byte |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |

## Verification
A directed sequence first walks through enabling transmit, write/load/done, a receive with a parity error, a double receive that overruns, clearing the status, 7-bit reads, synchronous mode and disabling the port. This isolates each set and clear rule. Random traffic then overlaps engine pulses with bus accesses in the same cycle. That traffic tells apart the tie priorities: read against a new receive, status clear against new errors, data write against load or done, and interrupt set against clear. Occasional random control writes toggle mode, character length and enable under live traffic, and show that disabled-port pulses leave no trace.

// File: rtl/sio_flag_ctrl.sv
module sio_flag_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] tx_data,
  output logic          tx_irq,
  input  logic          tx_irq_clr,
  input  logic          tx_load,
  input  logic          tx_done,
  input  logic          rx_xfer,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr
);
  localparam int TOP = DW - 1;

  logic [DW-1:0] ctrl_q, rx_q, tx_q;
  logic [6:0]    st_q, st_d;
  logic          irq_q;

  wire port_on = ctrl_q[TOP];
  wire uart    = ~ctrl_q[1];
  wire char7   = ctrl_q[2];
  wire wr_dat  = bus_wr && bus_sel == 2'd0;
  wire wr_sts  = bus_wr && bus_sel == 2'd1;
  wire wr_ctl  = bus_wr && bus_sel == 2'd2;
  wire rd_dat  = bus_rd && bus_sel == 2'd0;
  wire tx_rise = wr_ctl && bus_wdata[TOP] && bus_wdata[0] && !(ctrl_q[TOP] && ctrl_q[0]);
  wire ovr     = rx_xfer && st_q[1] && !rd_dat;

  always_comb begin
    st_d = st_q;
    if (port_on) begin
      if (tx_load) st_d[0] = 1'b1;
      if (tx_done) st_d[2] = 1'b1;
      if (rd_dat)  st_d[1] = 1'b0;
      if (wr_sts)  st_d[6:3] = 4'b0;
      if (rx_xfer) begin
        st_d[1] = 1'b1;
        if (ovr)             st_d[3] = 1'b1;
        if (uart && rx_perr) st_d[4] = 1'b1;
        if (uart && rx_ferr) st_d[5] = 1'b1;
        if (uart && (ovr || rx_perr || rx_ferr)) st_d[6] = 1'b1;
      end
      if (wr_dat) begin
        st_d[0] = 1'b0;
        st_d[2] = 1'b0;
      end
    end
    if (wr_ctl && !bus_wdata[TOP]) st_d = '0;
    else if (tx_rise) begin
      st_d[0] = 1'b1;
      st_d[2] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      st_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_ctl) ctrl_q <= bus_wdata;
      if (wr_dat) tx_q <= bus_wdata;
      if (rx_xfer && port_on) rx_q <= rx_data;
      if (tx_rise) irq_q <= 1'b1;
      else if (tx_irq_clr) irq_q <= 1'b0;
    end
  end

  wire [DW-1:0] rx_view = char7 ? {1'b0, rx_q[TOP-1:0]} : rx_q;
  wire [6:0]    st_view = {st_q[6:4] & {3{uart}}, st_q[3:0]};

  always_comb begin
    case (bus_sel)
      2'd0:    bus_rdata = rx_view;
      2'd1:    bus_rdata = DW'(st_view);
      2'd2:    bus_rdata = ctrl_q;
      default: bus_rdata = '0;
    endcase
  end

  assign tx_data = tx_q;
  assign tx_irq  = irq_q;
endmodule

// File: rtl/sio_flag_ctrl_chk.sv
module sio_flag_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_sel,
  input logic [DW-1:0] bus_wdata,
  input logic          rx_xfer,
  input logic [DW-1:0] ctrl_q,
  input logic [6:0]    st_q,
  input logic          tx_irq
);
  // R9
  tx_enable_prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd2 && bus_wdata[DW-1] && bus_wdata[0] && !(ctrl_q[DW-1] && ctrl_q[0]))
    |=> (tx_irq && st_q[0] && st_q[2]));

  // R8
  disable_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd2 && !bus_wdata[DW-1]) |=> (st_q == 7'd0));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1 && ctrl_q[DW-1] && !rx_xfer) |=> (st_q[6:3] == 4'd0));

  // R6
  read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == 2'd0 && ctrl_q[DW-1] && !rx_xfer) |=> !st_q[1]);

  // R4
  rx_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_xfer && ctrl_q[DW-1] && !(bus_wr && bus_sel == 2'd2)) |=> st_q[1]);

  // R11
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[DW-1] && !(bus_wr && bus_sel == 2'd2)) |=> $stable(st_q));
endmodule

bind sio_flag_ctrl sio_flag_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .rx_xfer(rx_xfer), .ctrl_q(ctrl_q), .st_q(st_q), .tx_irq(tx_irq)
);

// File: tb/test_sio_flag_ctrl.sv
module test_sio_flag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, tx_irq_clr = 0, tx_load = 0, tx_done = 0;
  logic rx_xfer = 0, rx_perr = 0, rx_ferr = 0;
  logic [1:0] bus_sel = 0;
  logic [7:0] bus_wdata = 0, rx_data = 0;
  logic [7:0] bus_rdata, tx_data;
  logic tx_irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sio_flag_ctrl #(.DW(8)) i_sio_flag_ctrl (.*);

  logic [7:0] m_ctrl = 0, m_rx = 0, m_tx = 0;
  logic [6:0] m_st = 0;
  logic m_irq = 0;

  function automatic logic [7:0] exp_rd(input logic [1:0] s);
    logic uart_m = ~m_ctrl[1];
    case (s)
      2'd0: return m_ctrl[2] ? {1'b0, m_rx[6:0]} : m_rx;
      2'd1: return {1'b0, m_st[6:4] & {3{uart_m}}, m_st[3:0]};
      2'd2: return m_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic on = m_ctrl[7];
    logic uart_m = ~m_ctrl[1];
    logic rdd = bus_rd && bus_sel == 0;
    logic wctl = bus_wr && bus_sel == 2;
    logic rise = wctl && bus_wdata[7] && bus_wdata[0] && !(m_ctrl[7] && m_ctrl[0]);
    logic [6:0] n = m_st;
    if (on) begin
      if (tx_load) n[0] = 1;
      if (tx_done) n[2] = 1;
      if (rdd) n[1] = 0;
      if (bus_wr && bus_sel == 1) n[6:3] = 0;
      if (rx_xfer) begin
        logic o = m_st[1] && !rdd;
        n[1] = 1;
        n[3] = n[3] | o;
        n[4] = n[4] | (uart_m & rx_perr);
        n[5] = n[5] | (uart_m & rx_ferr);
        n[6] = n[6] | (uart_m & (o | rx_perr | rx_ferr));
        m_rx = rx_data;
      end
      if (bus_wr && bus_sel == 0) begin n[0] = 0; n[2] = 0; end
    end
    if (wctl && !bus_wdata[7]) n = 0;
    else if (rise) begin n[0] = 1; n[2] = 1; end
    if (bus_wr && bus_sel == 0) m_tx = bus_wdata;
    if (rise) m_irq = 1; else if (tx_irq_clr) m_irq = 0;
    if (wctl) m_ctrl = bus_wdata;
    m_st = n;
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [1:0] sel, input logic [7:0] wd,
                     input logic rx, input logic [7:0] rdat, input logic pe, input logic fe,
                     input logic tl, input logic td, input logic ic);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = wd;
    rx_xfer = rx; rx_data = rdat; rx_perr = pe; rx_ferr = fe;
    tx_load = tl; tx_done = td; tx_irq_clr = ic;
    #1;
    chk(sel == 0 ? "R1 read" : sel == 1 ? "R3 status" : "ctrl", bus_rdata, exp_rd(sel));
    chk("R9 irq", {7'd0, tx_irq}, {7'd0, m_irq});
    chk("R1 tx_data", tx_data, m_tx);
    model_step();
  endtask

  task automatic peek(input logic [1:0] sel);
    cyc(0, 0, sel, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek(1); chk("R3 reset status", bus_rdata, 8'h00);
    peek(2); chk("R3 reset ctrl", bus_rdata, 8'h00);
    cyc(1, 0, 2, 8'h81, 0, 0, 0, 0, 0, 0, 0);
    peek(1); chk("R9 enable primes flags", bus_rdata, 8'h05);
    chk("R9 irq raised", {7'd0, tx_irq}, 8'h01);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    peek(1); chk("R9 irq cleared", {7'd0, tx_irq}, 8'h00);
    cyc(1, 0, 0, 8'hA5, 0, 0, 0, 0, 0, 0, 0);
    peek(1); chk("R10 write clears", bus_rdata, 8'h00);
    chk("R1 tx byte", tx_data, 8'hA5);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    peek(1); chk("R10 load sets empty", bus_rdata, 8'h01);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0);
    peek(1); chk("R10 done sets complete", bus_rdata, 8'h05);
    cyc(0, 0, 1, 0, 1, 8'hC3, 1, 0, 0, 0, 0);
    peek(1); chk("R4 rx with parity", bus_rdata, 8'h57);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 rx byte", bus_rdata, 8'hC3);
    peek(1); chk("R6 read clears full", bus_rdata, 8'h55);
    cyc(0, 0, 1, 0, 1, 8'h11, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 8'h22, 0, 0, 0, 0, 0);
    peek(1); chk("R4 overrun", bus_rdata, 8'h5F);
    peek(0); chk("R4 overwritten", bus_rdata, 8'h22);
    cyc(1, 0, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    peek(1); chk("R7 status write", bus_rdata, 8'h07);
    cyc(1, 0, 2, 8'h85, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 no re-raise", {7'd0, tx_irq}, 8'h00);
    cyc(0, 0, 1, 0, 1, 8'hFF, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 7-bit mask", bus_rdata, 8'h7F);
    cyc(1, 0, 2, 8'h87, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 8'h3C, 1, 1, 0, 0, 0);
    peek(1); chk("R5 sync no frame errors", bus_rdata, 8'h07);
    cyc(1, 0, 2, 8'h07, 0, 0, 0, 0, 0, 0, 0);
    peek(1); chk("R8 disable wipes", bus_rdata, 8'h00);
    cyc(0, 0, 1, 0, 1, 8'h99, 1, 1, 1, 1, 0);
    cyc(1, 0, 0, 8'h12, 0, 0, 0, 0, 0, 0, 0);
    peek(1); chk("R11 ignored when off", bus_rdata, 8'h00);
    void'($urandom(32'd1234));
    cyc(1, 0, 2, 8'h81, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 39);
      logic [7:0] wd = 8'($urandom);
      logic wr = 0, rd = 0;
      logic [1:0] sel = 2'($urandom_range(0, 3));
      if (op < 6) begin wr = 1; sel = 0; end
      else if (op < 14) begin rd = 1; sel = 0; end
      else if (op < 17) begin wr = 1; sel = 1; end
      else if (op == 17) begin
        wr = 1; sel = 2;
        wd[7] = ($urandom_range(0, 7) != 0);
        wd[6:3] = 0;
      end
      cyc(wr, rd, sel, wd, ($urandom_range(0, 3) == 0), 8'($urandom),
          ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 7) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule